// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block is the internal write controller of a small byte-wide non-volatile array. It receives requests that are already decoded: byte program with an address and a data byte, whole-array erase, a one-time lock of the low boot region, and entry to or exit from an identification mode. A separate read port returns one byte per request. Program and erase are timed by an internal cycle counter, and `busy` stays high for the whole operation. While the counter runs, a read returns a status byte in place of array data, so that software can poll for completion.

A program can only clear bits: the stored result is the old byte ANDed with the new data. Only an erase sets bits back to 1. After the boot lock is set, program and erase both leave the boot region untouched, and the rest of the array stays writable. In identification mode, three low addresses return fixed codes and the lock status.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, `busy` is low, identification mode is off and the boot region is unlocked.
- R2: A program request (`req_op` = 0) leaves the addressed byte holding the old value ANDed with `req_data`. A bit that is 0 never returns to 1 through a program.
- R3: A read sampled while busy returns bits 5:0 as zero. Bit 7 is the complement of bit 7 of the data being programmed during a program, and is 0 during an erase.
- R4: Bit 6 of status reads is 0 on the first read after an operation starts and inverts on each further read while busy. Once `busy` is low, reads return stored data.
- R5: `busy` rises in the cycle after an accepted program or erase. It stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, and the array changes only when it falls.
- R6: Each `rd_en` pulse produces `rd_valid` with `rd_data` one cycle later.
- R7: Any request that arrives while `busy` is high is ignored.
- R8: An erase request (`req_op` = 1) sets every unprotected byte to 0xFF.
- R9: A lock request (`req_op` = 2) takes effect at once and stays set until reset. After that, the bytes at addresses below 2**BOOT_W are not changed by program or erase, and bytes at higher addresses are.
- R10: Identification mode is entered with `req_op` = 3 and left with `req_op` = 4. In this mode, reads that are not busy return 0x1F at address 0, 0x0B at address 1, the lock state in bit 0 at address 2 (all other bits 0), and 0x00 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code (0 program, 1 erase, 2 lock, 3 id on, 4 id off) |
| req_addr | input | ADDR_W | Program address |
| req_data | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result or status byte |
| rd_valid | output | 1 | `rd_data` valid |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench builds the block with ADDR_W=8, BOOT_W=4, PROG_CYC=6 and ERASE_CYC=20. A 256-byte array with a 16-byte boot region lets one run cover several full erases, the boot boundary at 0x0F/0x10, and lock behaviour on both sides of it. Short program and erase windows allow exact counts of busy cycles, and they still leave room for two status reads inside one program, so both the polling bit and the toggle sequence can be observed before true data returns.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_ERASE  = 3'd1,
    OP_LOCK   = 3'd2,
    OP_ID_ON  = 3'd3,
    OP_ID_OFF = 3'd4
  } pe_op_e;

  typedef enum logic [1:0] {
    JOB_NONE  = 2'd0,
    JOB_PROG  = 2'd1,
    JOB_ERASE = 2'd2
  } pe_job_e;

  localparam logic [7:0] MFR_CODE = 8'h1F;
  localparam logic [7:0] DEV_CODE = 8'h0B;
endpackage

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(ERASE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign cnt_en = start_prog | start_erase | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_prog) begin
      cnt_d  = CNT_W'(PROG_CYC - 1);
      busy_d = 1'b1;
    end else if (start_erase) begin
      cnt_d  = CNT_W'(ERASE_CYC - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int ADDR_W = 9,
  parameter int BOOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_prog,
  input  logic              commit_erase,
  input  logic              lock_set,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              locked
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int BOOT_BYTES = 1 << BOOT_W;

  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       mem_d [DEPTH];
  logic [DEPTH-1:0] guard;
  logic             lock_q;
  logic             mem_en;

  // per-byte protection: only the low boot window can be guarded
  for (genvar g = 0; g < DEPTH; g++) begin : g_guard
    if (g < BOOT_BYTES) begin : g_boot
      assign guard[g] = lock_q;
    end else begin : g_main
      assign guard[g] = 1'b0;
    end
  end

  assign mem_en = commit_prog | commit_erase;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (!guard[i]) begin
        if (commit_erase)
          mem_d[i] = 8'hFF;
        else if (commit_prog && (wr_addr == ADDR_W'(i)))
          mem_d[i] = mem_q[i] & wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (mem_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  assign rd_byte = mem_q[rd_addr];
  assign locked  = lock_q;
endmodule

// File: rtl/flash_pe_readout.sv
module flash_pe_readout
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              op_start,
  input  pe_job_e           job,
  input  logic              load_bit7,
  input  logic              id_mode,
  input  logic              locked,
  input  logic [7:0]        mem_byte,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  logic       tog_q, tog_d, tog_en;
  logic [7:0] data_q, data_d;
  logic       valid_q;
  logic       poll_bit;

  assign poll_bit = (job == JOB_PROG) ? ~load_bit7 : 1'b0;

  assign tog_en = op_start | (rd_en & busy);
  assign tog_d  = op_start ? 1'b0 : ~tog_q;

  always_comb begin
    if (busy) begin
      data_d = {poll_bit, tog_q, 6'b0};
    end else if (id_mode) begin
      if (rd_addr == ADDR_W'(0))      data_d = MFR_CODE;
      else if (rd_addr == ADDR_W'(1)) data_d = DEV_CODE;
      else if (rd_addr == ADDR_W'(2)) data_d = {7'b0, locked};
      else                            data_d = 8'h00;
    end else begin
      data_d = mem_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= rd_en;
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BOOT_W    = 5,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy
);
  logic              accept;
  logic              start_prog, start_erase, op_start;
  logic              lock_req, id_on_req, id_off_req;
  logic              done;
  logic              commit_prog, commit_erase;
  logic              locked;
  logic [7:0]        mem_byte;
  logic [ADDR_W-1:0] ld_addr_q;
  logic [7:0]        ld_data_q;
  pe_job_e           job_q, job_d;
  logic              id_q, id_d, id_en;

  assign accept      = req_valid & ~busy;
  assign start_prog  = accept && (req_op == OP_PROG);
  assign start_erase = accept && (req_op == OP_ERASE);
  assign lock_req    = accept && (req_op == OP_LOCK);
  assign id_on_req   = accept && (req_op == OP_ID_ON);
  assign id_off_req  = accept && (req_op == OP_ID_OFF);
  assign op_start    = start_prog | start_erase;

  assign commit_prog  = done && (job_q == JOB_PROG);
  assign commit_erase = done && (job_q == JOB_ERASE);

  always_comb begin
    job_d = job_q;
    if (start_prog)       job_d = JOB_PROG;
    else if (start_erase) job_d = JOB_ERASE;
    else if (done)        job_d = JOB_NONE;
  end

  assign id_en = id_on_req | id_off_req;
  assign id_d  = id_on_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) job_q <= JOB_NONE;
    else        job_q <= job_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_addr_q <= '0;
      ld_data_q <= '0;
    end else if (start_prog) begin
      ld_addr_q <= req_addr;
      ld_data_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= 1'b0;
    else if (id_en) id_q <= id_d;
  end

  flash_pe_timer #(
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .busy       (busy),
    .done       (done)
  );

  flash_pe_array #(
    .ADDR_W(ADDR_W),
    .BOOT_W(BOOT_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_prog (commit_prog),
    .commit_erase(commit_erase),
    .lock_set    (lock_req),
    .wr_addr     (ld_addr_q),
    .wr_data     (ld_data_q),
    .rd_addr     (rd_addr),
    .rd_byte     (mem_byte),
    .locked      (locked)
  );

  flash_pe_readout #(
    .ADDR_W(ADDR_W)
  ) u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .op_start (op_start),
    .job      (job_q),
    .load_bit7(ld_data_q[7]),
    .id_mode  (id_q),
    .locked   (locked),
    .mem_byte (mem_byte),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/flash_pe_engine_chk.sv
module flash_pe_engine_chk #(
  parameter int ERASE_CYC = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       rd_en,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       locked
);
  localparam int CW = $clog2(ERASE_CYC + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_status_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(busy)) |-> (rd_data[5:0] == 6'b0));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CW'(ERASE_CYC)));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

bind flash_pe_engine flash_pe_engine_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .busy     (busy),
  .locked   (locked)
);

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;
  localparam int AW = 8;
  localparam int PC = 6;
  localparam int EC = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          busy;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done_f = 0;

  always #5 clk = ~clk;

  flash_pe_engine #(
    .ADDR_W(AW), .BOOT_W(4), .PROG_CYC(PC), .ERASE_CYC(EC)
  ) u_flash_pe_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned byte against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        check("R6 unexpected rd_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, int'(rd_data), int'(e.val));
      end
    end
  end

  task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [7:0] exp, string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // counts busy cycles; call right after issue()
  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic program_byte(logic [AW-1:0] a, logic [7:0] d);
    issue(3'd0, a, d);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 busy after reset", int'(busy), 0);
    do_read(8'h05, 8'hFF, "R1 erased byte 0x05");
    do_read(8'h03, 8'hFF, "R1 erased byte 0x03");
    issue(3'd3, '0, '0);
    do_read(8'h02, 8'h00, "R1 unlocked after reset");
    issue(3'd4, '0, '0);

    // R2/R5 program and its duration
    issue(3'd0, 8'h20, 8'hA5);
    busy_len(n);
    check("R5 program busy length", n, PC);
    do_read(8'h20, 8'hA5, "R2 first program");
    program_byte(8'h20, 8'h3C);
    do_read(8'h20, 8'h24, "R2 program ANDs with old value");

    // R3/R4 status reads during program
    issue(3'd0, 8'h30, 8'h5A);
    do_read(8'h30, 8'h80, "R3 poll bit first read");
    do_read(8'h30, 8'hC0, "R4 toggle second read");
    wait_idle();
    do_read(8'h30, 8'h5A, "R4 true data after program");
    do_read(8'h30, 8'h5A, "R4 no toggle when idle");
    issue(3'd0, 8'h31, 8'h80);
    do_read(8'h31, 8'h00, "R3 poll bit with data bit7 set");
    wait_idle();
    do_read(8'h31, 8'h80, "R2 second program result");

    // R7 requests while busy ignored
    issue(3'd0, 8'h40, 8'h00);
    issue(3'd1, 8'h00, 8'h00);
    issue(3'd0, 8'h41, 8'h00);
    wait_idle();
    do_read(8'h41, 8'hFF, "R7 program while busy ignored");
    do_read(8'h40, 8'h00, "R7 erase while busy ignored");

    // R10 identification mode
    issue(3'd3, '0, '0);
    do_read(8'h00, 8'h1F, "R10 manufacturer code");
    do_read(8'h01, 8'h0B, "R10 device code");
    do_read(8'h07, 8'h00, "R10 other address");
    issue(3'd4, '0, '0);
    do_read(8'h20, 8'h24, "R10 data after exit");

    // R9 boot lock
    program_byte(8'h03, 8'h0F);
    do_read(8'h03, 8'h0F, "R9 boot byte writable before lock");
    issue(3'd2, '0, '0);
    issue(3'd3, '0, '0);
    do_read(8'h02, 8'h01, "R9 lock status reads 1");
    issue(3'd4, '0, '0);
    program_byte(8'h03, 8'h00);
    do_read(8'h03, 8'h0F, "R9 locked boot byte kept");
    program_byte(8'h0F, 8'h00);
    do_read(8'h0F, 8'hFF, "R9 top boot byte kept");
    program_byte(8'h10, 8'h00);
    do_read(8'h10, 8'h00, "R9 first main byte writable");

    // R8/R5 erase
    issue(3'd1, '0, '0);
    busy_len(n);
    check("R5 erase busy length", n, EC);
    do_read(8'h03, 8'h0F, "R9 erase skips boot region");
    do_read(8'h10, 8'hFF, "R8 erase main byte 0x10");
    do_read(8'h20, 8'hFF, "R8 erase main byte 0x20");
    program_byte(8'h50, 8'h11);
    issue(3'd1, '0, '0);
    do_read(8'h50, 8'h00, "R3 erase status poll bit 0");
    do_read(8'h50, 8'h40, "R4 erase status toggles");
    do_read(8'h50, 8'h00, "R4 erase status toggles back");
    wait_idle();
    do_read(8'h50, 8'hFF, "R8 erase after program");

    repeat (3) @(negedge clk);
    check("R6 all reads returned", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done_f = 1;
    $finish;
  end
endmodule